// File: doc/BRIEF.md
# Fuse and Lock Configuration Programmer

This block is the target side of a byte-wide parallel programming port. It holds only the configuration storage of a small controller: three fuse bytes (low, high, extended) and one lock byte. An external programmer loads a command byte and a data byte into the block over a shared 8-bit bidirectional bus. A falling edge on the active-low write strobe then starts a timed write, and the selected byte is driven back onto the bus while the active-low output enable is asserted. In every stored byte a 0 bit means "programmed" and a 1 bit means "unprogrammed".

The lock byte can only be programmed toward 0. The only way to return it to all ones is a chip-erase command, and chip erase leaves the fuses alone. The two lowest lock bits together set the protection mode. When both are programmed, the boot-lock bits (bits 5 to 2) cannot be changed by any later lock write. A ready/busy output goes low for a parameterized number of clock cycles after each accepted write. Write strobes that arrive while it is low are discarded.

All strobes are sampled on the rising edge of `clk`. A load happens in any cycle where `ld_stb` is high, and the action code selects what is loaded.

Top module: `cfg_prog_engine`

## Requirements
- R1: When reset is released, `rdy` is 1, the bus is not driven, and the fuse low, fuse high, extended fuse and lock bytes hold their parameter defaults (0x62, 0x99, 0xFF and 0xFF).
- R2: In a cycle with `ld_stb` high, `act_sel` = 2'b10 loads the bus value as the command and `act_sel` = 2'b01 loads it as the data byte. `act_sel` = 2'b00 and 2'b11 load nothing.
- R3: With command 0x40, a write replaces one fuse byte with the data byte. `bsel` = 2'b00 picks the low byte, 2'b01 picks the high byte and 2'b10 picks the extended byte. `bsel` = 2'b11 writes nothing.
- R4: With command 0x04 and `oe_n` low, the bus carries the fuse low byte for `bsel` = 2'b00, the fuse high byte for 2'b11, the extended byte for 2'b10 and the lock byte for 2'b01.
- R5: Whenever `oe_n` is high, or the current command is not 0x04, the block leaves the bus undriven.
- R6: A write starts when `wr_n` is sampled low after being sampled high while `rdy` is 1. `rdy` then reads 0 for exactly BUSY_CYC (default 8) cycles, starting on the first clock edge after the start.
- R7: A falling `wr_n` seen while `rdy` is 0 is ignored and changes no stored byte.
- R8: With command 0x20, each lock bit whose data bit is 0 becomes 0. Lock bits never change from 0 to 1 except through chip erase.
- R9: If lock bits 1 and 0 are both 0 when a lock write starts, lock bits 5 to 2 keep their values.
- R10: Command 0x80 (chip erase) sets the lock byte to 0xFF and leaves all three fuse bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_io | inout | 8 | Shared command, data and read-back bus |
| act_sel | input | 2 | Load action: 10 command, 01 data |
| ld_stb | input | 1 | Load strobe, sampled per clock |
| bsel | input | 2 | Byte select for writes and reads |
| wr_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| rdy | output | 1 | 1 = ready, 0 = write in progress |

## Verification
The bench counts the busy window exactly. A timer that is one cycle off in either direction changes that count. It issues a second write strobe during a write. A design that does not gate on busy would then overwrite the first fuse value. It checks that lock writes cannot clear bits and that erase touches only the lock byte. A lock byte that simply takes the data, or an erase that also resets the fuses, fails there. Finally it programs boot-lock bits after both mode bits are set. A design that skips the mode check would clear bits 5 to 2.

// File: rtl/cfg_prog_pkg.sv
// Shared widths, command codes and field positions for the configuration programmer.
package cfg_prog_pkg;
    localparam int CFG_W = 8;

    localparam logic [CFG_W-1:0] CMD_NOP   = 8'h00;
    localparam logic [CFG_W-1:0] CMD_READ  = 8'h04;
    localparam logic [CFG_W-1:0] CMD_LOCK  = 8'h20;
    localparam logic [CFG_W-1:0] CMD_FUSE  = 8'h40;
    localparam logic [CFG_W-1:0] CMD_ERASE = 8'h80;

    // Load action codes on act_sel
    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_DATA = 2'b01,
        ACT_CMD  = 2'b10,
        ACT_RSVD = 2'b11
    } act_e;

    // Lock byte layout: mode bits and boot-lock bits
    localparam int LK_MODE_LO = 0;
    localparam int LK_MODE_HI = 1;
    localparam int LK_BOOT_LO = 2;
    localparam int LK_BOOT_HI = 5;
endpackage

// File: rtl/cfg_cmd_latch.sv
// Holds the last command and data byte loaded from the shared bus.
// Assumes ld_stb and act_sel are stable around the sampling clock edge.
module cfg_cmd_latch
    import cfg_prog_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_stb,
    input  logic [1:0]   act_sel,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] cmd_q,
    output logic [W-1:0] data_q
);
    // Capture command or data according to the action code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            data_q <= '1;
        end else if (ld_stb) begin
            if (act_e'(act_sel) == ACT_CMD)  cmd_q  <= bus_in;
            if (act_e'(act_sel) == ACT_DATA) data_q <= bus_in;
        end
    end
endmodule

// File: rtl/cfg_wr_timer.sv
// Detects a falling write strobe and runs the busy window.
// Assumes wr_n is synchronous to clk; strobes during the busy window are dropped.
module cfg_wr_timer #(
    parameter int BUSY_CYC = 8,
    localparam int CNT_W = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    output logic start,
    output logic rdy
);
    logic             wr_q;
    logic [CNT_W-1:0] cnt_q;

    assign rdy   = (cnt_q == '0);
    assign start = wr_q && !wr_n && rdy;

    // Remember the previous strobe level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= 1'b1;
        else        wr_q <= wr_n;
    end

    // Load the busy count on a start, count it down otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (start)      cnt_q <= CNT_W'(BUSY_CYC);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/cfg_store.sv
// Register model of the fuse bytes and the one-way lock byte.
// Commits a write in the cycle it starts; the lock mode is taken before the write.
module cfg_store
    import cfg_prog_pkg::*;
#(
    parameter int           W          = CFG_W,
    parameter logic [W-1:0] FUSE_LO_RV = 8'h62,
    parameter logic [W-1:0] FUSE_HI_RV = 8'h99,
    parameter logic [W-1:0] FUSE_EX_RV = 8'hFF,
    parameter logic [W-1:0] LOCK_RV    = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] cmd,
    input  logic [W-1:0] data,
    input  logic [1:0]   bsel,
    output logic [W-1:0] fuse_lo_q,
    output logic [W-1:0] fuse_hi_q,
    output logic [W-1:0] fuse_ex_q,
    output logic [W-1:0] lock_q
);
    logic         mode3;
    logic [W-1:0] lock_nxt;

    assign mode3 = !lock_q[LK_MODE_HI] && !lock_q[LK_MODE_LO];

    // Next lock value: only clear bits, keep boot bits when mode 3 is active
    always_comb begin
        lock_nxt = lock_q & data;
        if (mode3) lock_nxt[LK_BOOT_HI:LK_BOOT_LO] = lock_q[LK_BOOT_HI:LK_BOOT_LO];
    end

    // Apply fuse, lock and erase writes on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_lo_q <= FUSE_LO_RV;
            fuse_hi_q <= FUSE_HI_RV;
            fuse_ex_q <= FUSE_EX_RV;
            lock_q    <= LOCK_RV;
        end else if (start) begin
            case (cmd)
                CMD_FUSE: begin
                    case (bsel)
                        2'b00:   fuse_lo_q <= data;
                        2'b01:   fuse_hi_q <= data;
                        2'b10:   fuse_ex_q <= data;
                        default: ;
                    endcase
                end
                CMD_LOCK:  lock_q <= lock_nxt;
                CMD_ERASE: lock_q <= '1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_prog_engine.sv
// Top of the fuse and lock programmer: load path, write timer, storage, read-back.
// Assumes all strobes are synchronous to clk; the bus is driven only for reads.
module cfg_prog_engine
    import cfg_prog_pkg::*;
#(
    parameter int BUSY_CYC = 8,
    parameter logic [CFG_W-1:0] FUSE_LO_RV = 8'h62,
    parameter logic [CFG_W-1:0] FUSE_HI_RV = 8'h99,
    parameter logic [CFG_W-1:0] FUSE_EX_RV = 8'hFF,
    parameter logic [CFG_W-1:0] LOCK_RV    = 8'hFF
) (
    input  wire              clk,
    input  wire              rst_n,
    inout  wire [CFG_W-1:0]  data_io,
    input  wire [1:0]        act_sel,
    input  wire              ld_stb,
    input  wire [1:0]        bsel,
    input  wire              wr_n,
    input  wire              oe_n,
    output logic             rdy
);
    logic [CFG_W-1:0] cmd_q, data_q;
    logic [CFG_W-1:0] fuse_lo_q, fuse_hi_q, fuse_ex_q, lock_q;
    logic [CFG_W-1:0] rd_byte;
    logic             start, drv_en;

    cfg_cmd_latch #(.W(CFG_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .act_sel(act_sel),
        .bus_in(data_io), .cmd_q(cmd_q), .data_q(data_q)
    );

    cfg_wr_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .start(start), .rdy(rdy)
    );

    cfg_store #(
        .W(CFG_W), .FUSE_LO_RV(FUSE_LO_RV), .FUSE_HI_RV(FUSE_HI_RV),
        .FUSE_EX_RV(FUSE_EX_RV), .LOCK_RV(LOCK_RV)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd_q), .data(data_q),
        .bsel(bsel), .fuse_lo_q(fuse_lo_q), .fuse_hi_q(fuse_hi_q),
        .fuse_ex_q(fuse_ex_q), .lock_q(lock_q)
    );

    // Pick the byte requested by the read select code
    always_comb begin
        case (bsel)
            2'b00:   rd_byte = fuse_lo_q;
            2'b11:   rd_byte = fuse_hi_q;
            2'b10:   rd_byte = fuse_ex_q;
            default: rd_byte = lock_q;
        endcase
    end

    assign drv_en  = !oe_n && (cmd_q == CMD_READ);
    assign data_io = drv_en ? rd_byte : {CFG_W{1'bz}};
endmodule

// File: rtl/cfg_prog_chk.sv
// Protocol checker for cfg_prog_engine, bound into every instance.
module cfg_prog_chk
    import cfg_prog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_n,
    input logic             rdy,
    input logic [1:0]       bsel,
    input logic [CFG_W-1:0] cmd_q,
    input logic [CFG_W-1:0] fuse_lo_q,
    input logic [CFG_W-1:0] fuse_hi_q,
    input logic [CFG_W-1:0] fuse_ex_q,
    input logic [CFG_W-1:0] lock_q
);
    assert_busy_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && $fell(wr_n)) |=> !rdy);

    assert_no_write_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> ($stable(fuse_lo_q) && $stable(fuse_hi_q) && $stable(fuse_ex_q) && $stable(lock_q)));

    assert_lock_one_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdy && $fell(wr_n) && cmd_q == CMD_ERASE) |=> ((lock_q & ~$past(lock_q)) == '0));

    assert_boot_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q[LK_MODE_HI:LK_MODE_LO] == 2'b00 && !(rdy && $fell(wr_n) && cmd_q == CMD_ERASE))
        |=> $stable(lock_q[LK_BOOT_HI:LK_BOOT_LO]));

    assert_fuse_bad_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && $fell(wr_n) && cmd_q == CMD_FUSE && bsel == 2'b11)
        |=> ($stable(fuse_lo_q) && $stable(fuse_hi_q) && $stable(fuse_ex_q)));

    assert_erase_keeps_fuses_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && $fell(wr_n) && cmd_q == CMD_ERASE)
        |=> ($stable(fuse_lo_q) && $stable(fuse_hi_q) && $stable(fuse_ex_q)));
endmodule

bind cfg_prog_engine cfg_prog_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rdy(rdy), .bsel(bsel), .cmd_q(cmd_q),
    .fuse_lo_q(fuse_lo_q), .fuse_hi_q(fuse_hi_q), .fuse_ex_q(fuse_ex_q), .lock_q(lock_q)
);

// File: tb/cfg_prog_engine_tb_top.sv
// Directed bench for cfg_prog_engine: one task per scenario.
module cfg_prog_engine_tb_top;
    localparam int BUSY = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] act_sel = 2'b00;
    logic       ld_stb = 1'b0;
    logic [1:0] bsel = 2'b00;
    logic       wr_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       rdy;
    logic       tb_en = 1'b0;
    logic [7:0] tb_d = 8'h00;
    wire  [7:0] data_io;

    int n_chk = 0;
    int n_bad = 0;

    assign data_io = tb_en ? tb_d : 8'hzz;

    always #5 clk = ~clk;

    cfg_prog_engine #(.BUSY_CYC(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .data_io(data_io), .act_sel(act_sel),
        .ld_stb(ld_stb), .bsel(bsel), .wr_n(wr_n), .oe_n(oe_n), .rdy(rdy)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] act, input logic [7:0] v);
        @(negedge clk);
        act_sel = act; tb_d = v; tb_en = 1'b1; ld_stb = 1'b1;
        @(negedge clk);
        ld_stb = 1'b0; tb_en = 1'b0; act_sel = 2'b00;
    endtask

    // Pulse wr_n and return the number of cycles rdy stays low
    task automatic write(input logic [1:0] sel, output int busy);
        @(negedge clk);
        bsel = sel; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        busy = 0;
        while (!rdy && busy < 100) begin
            busy++;
            @(negedge clk);
        end
    endtask

    task automatic read(input logic [1:0] sel, output logic [7:0] v);
        load(2'b10, 8'h04);
        @(negedge clk);
        bsel = sel; oe_n = 1'b0;
        @(negedge clk);
        v = data_io;
        oe_n = 1'b1;
    endtask

    task automatic prog(input logic [7:0] cmd, input logic [7:0] d, input logic [1:0] sel);
        int b;
        load(2'b10, cmd);
        load(2'b01, d);
        write(sel, b);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 rdy", {7'd0, rdy}, 8'h01);
        read(2'b00, v); check("R1 fuse low", v, 8'h62);
        read(2'b11, v); check("R1 fuse high", v, 8'h99);
        read(2'b10, v); check("R1 ext", v, 8'hFF);
        read(2'b01, v); check("R1 lock", v, 8'hFF);
    endtask

    task automatic t_fuse;
        logic [7:0] v;
        int b;
        load(2'b10, 8'h40); load(2'b01, 8'h3A);
        write(2'b00, b);
        check("R6 busy cycles", 8'(b), 8'(BUSY));
        read(2'b00, v); check("R3 fuse low", v, 8'h3A);
        prog(8'h40, 8'hC5, 2'b01);
        read(2'b11, v); check("R3/R4 fuse high", v, 8'hC5);
        prog(8'h40, 8'h0F, 2'b10);
        read(2'b10, v); check("R3/R4 ext", v, 8'h0F);
        prog(8'h40, 8'h00, 2'b11);
        read(2'b00, v); check("R3 sel 11 low", v, 8'h3A);
        read(2'b11, v); check("R3 sel 11 high", v, 8'hC5);
        read(2'b10, v); check("R3 sel 11 ext", v, 8'h0F);
    endtask

    task automatic t_latch;
        logic [7:0] v;
        int b;
        load(2'b10, 8'h40); load(2'b01, 8'h55);
        load(2'b00, 8'h11); load(2'b11, 8'h22);
        write(2'b00, b);
        read(2'b00, v); check("R2 ignored codes", v, 8'h55);
    endtask

    task automatic t_busy_wr;
        logic [7:0] v;
        load(2'b10, 8'h40); load(2'b01, 8'h12);
        @(negedge clk); bsel = 2'b00; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        load(2'b01, 8'h34);
        @(negedge clk); wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        check("R7 still busy", {7'd0, rdy}, 8'h00);
        while (!rdy) @(negedge clk);
        read(2'b00, v); check("R7 second write dropped", v, 8'h12);
    endtask

    task automatic t_bus_release;
        logic [7:0] v;
        load(2'b10, 8'h40);
        @(negedge clk); bsel = 2'b00; oe_n = 1'b0; tb_d = 8'hA6; tb_en = 1'b1;
        @(negedge clk); v = data_io; tb_en = 1'b0; oe_n = 1'b1;
        check("R5 not read cmd", v, 8'hA6);
        load(2'b10, 8'h04);
        @(negedge clk); oe_n = 1'b1; tb_d = 8'h5B; tb_en = 1'b1;
        @(negedge clk); v = data_io; tb_en = 1'b0;
        check("R5 oe high", v, 8'h5B);
    endtask

    task automatic t_lock;
        logic [7:0] v;
        prog(8'h20, 8'hF7, 2'b00);
        read(2'b01, v); check("R8 boot bit programmed", v, 8'hF7);
        prog(8'h20, 8'hFF, 2'b00);
        read(2'b01, v); check("R8 no 1 restore", v, 8'hF7);
        prog(8'h80, 8'h00, 2'b00);
        read(2'b01, v); check("R10 erase lock", v, 8'hFF);
        read(2'b00, v); check("R10 fuse low kept", v, 8'h12);
        read(2'b11, v); check("R10 fuse high kept", v, 8'hC5);
        prog(8'h20, 8'hFC, 2'b00);
        read(2'b01, v); check("R8 mode bits", v, 8'hFC);
        prog(8'h20, 8'hC3, 2'b00);
        read(2'b01, v); check("R9 boot frozen", v, 8'hFC);
        prog(8'h80, 8'h00, 2'b00);
        read(2'b01, v); check("R10 erase again", v, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_fuse;
        t_latch;
        t_busy_wr;
        t_bus_release;
        t_lock;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule